// File: doc/BRIEF.md
# NAND Bus Timing Sequencer

This block turns single-byte requests into the control and data waveforms of an 8-bit raw NAND flash bus. Four kinds of request are supported: a command byte, an address byte, a data byte written to the device, and a data byte read from the device. Each request becomes one bus cycle made of a setup phase, a strobe phase and a hold phase. After these an optional ready-wait phase runs, and at its end the device ready/busy line is sampled into a status bit.

The phase lengths come from a 32-bit timing word that software writes. Read cycles and write cycles each have their own set of fields. The word is captured when a cycle starts, so software may rewrite it at any time. A configuration bit keeps chip enable asserted between cycles, so a multi-byte command sequence stays selected. A synchronous software reset returns the sequencer to idle and clears that configuration bit.

A host presents a request with a valid flag and a ready flag. It keeps the request stable until the request is accepted. Read results come back on a byte output with a one-cycle valid pulse.

Top module: `nand_bus_seq`

## Requirements
- R1: The timing word is split into eight 4-bit fields. Read fields: setup [3:0], hold [7:4], strobe width [11:8], ready-wait [15:12]. Write fields: setup [19:16], hold [23:20], strobe width [27:24], ready-wait [31:28]. A read request uses only the read fields. Every other request uses only the write fields.
- R2: A setup, strobe or hold field value N gives that phase N+1 clocks. The strobe (WE# for writes, RE# for reads) is low only during the strobe phase.
- R3: A ready-wait value n adds 2*n clocks after the hold phase, so a cycle keeps busy high for setup+width+hold+3+2*n clocks. The ready/busy input is sampled only on the clock edge that ends the cycle, and the status bit keeps that value until the next cycle ends.
- R4: req_op encoding: 0 = command (CLE high), 1 = address (ALE high), 2 = data write, 3 = data read. CLE or ALE is high during setup, strobe and hold only, and never both at once.
- R5: In a write-type cycle (op 0, 1 or 2), dq_oe is high and dq_o carries the request byte from the first setup clock to the last hold clock. Outside those clocks dq_oe is low.
- R6: In a read cycle dq_oe stays low. rd_data takes dq_i on the last clock of the RE# pulse. rd_valid is high for exactly the one clock that follows.
- R7: CE# is low for the whole of every busy cycle. While idle, CE# is low if and only if the chip-enable hold bit is set.
- R8: rdy_status is 1 when the sampled ready/busy input was 1 (device ready). It resets to 0.
- R9: A request is accepted only on a clock where req_valid is high and busy is low. busy rises on the next clock. A request held while busy waits, and is taken one idle clock after the current cycle ends.
- R10: The timing word is captured when a request is accepted. Writing a new word during a cycle changes only later cycles.
- R11: sw_reset returns the sequencer to idle on the next clock and clears the chip-enable hold bit, which deasserts CE# and both strobes.
- R12: WE# and RE# are never low together. While idle, both are high and dq_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software reset pulse |
| cfg_we | input | 1 | Write strobe for the chip-enable hold bit |
| cfg_ce_low | input | 1 | Value written to the chip-enable hold bit |
| tim_we | input | 1 | Write strobe for the timing word |
| tim_word | input | 32 | Timing word value |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Request kind (R4 encoding) |
| req_byte | input | 8 | Byte for command, address or write data |
| req_ready | output | 1 | Sequencer can accept a request |
| busy | output | 1 | Bus cycle in progress |
| rd_data | output | 8 | Byte captured by the last read cycle |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |
| rdy_status | output | 1 | Sampled device ready state, 1 = ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb | input | 1 | Device ready/busy, 1 = ready |

## Verification
The assertions check the following on every cycle:
- the strobes never overlap, and the bus is quiet while idle;
- CLE and ALE stay inside a cycle;
- the data bus is never driven during reads;
- CE# is low throughout a cycle;
- the read-valid pulse follows an RE# clock;
- a request is taken whenever the sequencer is free;
- the status bit changes only after a cycle end.

The exact phase lengths for each field value, the field positions, the clock on which read data and ready are sampled, the use of the captured timing word, and the held-request turnaround can only be shown by the bench. It sweeps timing words that include all-zero and all-fifteen fields, runs every request kind under each word, and compares the counted clocks against the field arithmetic.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  localparam int NBS_FW = 4;            // width of one timing field
  localparam int NBS_NF = 4;            // fields per direction
  localparam int NBS_TW = 2 * NBS_NF * NBS_FW;
  localparam int NBS_CW = NBS_FW + 1;   // phase counter width (holds 2*n-1)

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } nbs_op_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_WAIT  = 3'd4
  } nbs_phase_e;

  typedef struct packed {
    logic [NBS_FW-1:0] rwait;
    logic [NBS_FW-1:0] width;
    logic [NBS_FW-1:0] hold;
    logic [NBS_FW-1:0] setup;
  } nbs_timing_t;

  // counter preset for a setup/pulse/hold phase: N gives N+1 clocks
  function automatic logic [NBS_CW-1:0] phase_load(input logic [NBS_FW-1:0] n);
    return {1'b0, n};
  endfunction

  // counter preset for the ready-wait phase: n gives 2*n clocks
  function automatic logic [NBS_CW-1:0] wait_load(input logic [NBS_FW-1:0] n);
    return {n, 1'b0} - NBS_CW'(1);
  endfunction

  function automatic logic is_write_op(input nbs_op_e op);
    return op != OP_RDATA;
  endfunction

endpackage

// File: rtl/nbs_timing_select.sv
module nbs_timing_select
  import nbs_pkg::*;
(
  input  logic [NBS_TW-1:0] word,
  input  logic              rd_dir,
  output nbs_timing_t       sel
);
  localparam int HALF = NBS_NF * NBS_FW;

  logic [NBS_FW-1:0] rd_f [NBS_NF];
  logic [NBS_FW-1:0] wr_f [NBS_NF];

  // field g of each direction; read half in the low bits
  for (genvar g = 0; g < NBS_NF; g++) begin : g_field
    assign rd_f[g] = word[g*NBS_FW +: NBS_FW];
    assign wr_f[g] = word[HALF + g*NBS_FW +: NBS_FW];
  end

  always_comb begin
    if (rd_dir) begin
      sel.setup = rd_f[0];
      sel.hold  = rd_f[1];
      sel.width = rd_f[2];
      sel.rwait = rd_f[3];
    end else begin
      sel.setup = wr_f[0];
      sel.hold  = wr_f[1];
      sel.width = wr_f[2];
      sel.rwait = wr_f[3];
    end
  end
endmodule

// File: rtl/nbs_phase_fsm.sv
module nbs_phase_fsm
  import nbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_reset,
  input  logic        start,
  input  nbs_timing_t tim_sel,
  output nbs_phase_e  phase,
  output logic        pulse_last,
  output logic        cyc_end
);
  nbs_phase_e        ph_q;
  logic [NBS_CW-1:0] cnt_q;
  nbs_timing_t       tim_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tim_q <= '0;
    end else if (sw_reset) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            tim_q <= tim_sel;
            ph_q  <= PH_SETUP;
            cnt_q <= phase_load(tim_sel.setup);
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            ph_q  <= PH_PULSE;
            cnt_q <= phase_load(tim_q.width);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_PULSE: begin
          if (cnt_zero) begin
            ph_q  <= PH_HOLD;
            cnt_q <= phase_load(tim_q.hold);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            if (tim_q.rwait == '0) begin
              ph_q <= PH_IDLE;
            end else begin
              ph_q  <= PH_WAIT;
              cnt_q <= wait_load(tim_q.rwait);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt_zero) ph_q <= PH_IDLE;
          else          cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = ph_q;
  assign pulse_last = (ph_q == PH_PULSE) && cnt_zero;
  assign cyc_end    = ((ph_q == PH_HOLD) && cnt_zero && (tim_q.rwait == '0))
                   || ((ph_q == PH_WAIT) && cnt_zero);
endmodule

// File: rtl/nbs_pin_drive.sv
module nbs_pin_drive
  import nbs_pkg::*;
#(
  parameter int DW = 8
) (
  input  nbs_phase_e    phase,
  input  nbs_op_e       op,
  input  logic [DW-1:0] byte_q,
  input  logic          ce_force,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);
  logic active;
  logic strobe;
  logic wr;

  assign active = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_PULSE);
  assign wr     = is_write_op(op);

  assign ce_n  = !((phase != PH_IDLE) || ce_force);
  assign cle   = active && (op == OP_CMD);
  assign ale   = active && (op == OP_ADDR);
  assign we_n  = !(strobe && wr);
  assign re_n  = !(strobe && !wr);
  assign dq_oe = active && wr;

  for (genvar g = 0; g < DW; g++) begin : g_dq
    assign dq_o[g] = dq_oe & byte_q[g];
  end
endmodule

// File: rtl/nbs_sampler.sv
module nbs_sampler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_reset,
  input  logic          pulse_last,
  input  logic          rd_dir,
  input  logic          cyc_end,
  input  logic [DW-1:0] dq_i,
  input  logic          rb,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rdy_status
);
  logic cap;

  assign cap = pulse_last && rd_dir && !sw_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rdy_status <= 1'b0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= dq_i;
      if (cyc_end && !sw_reset) rdy_status <= rb;
    end
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              cfg_we,
  input  logic              cfg_ce_low,
  input  logic              tim_we,
  input  logic [NBS_TW-1:0] tim_word,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [DW-1:0]     req_byte,
  output logic              req_ready,
  output logic              busy,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              rdy_status,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DW-1:0]     nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DW-1:0]     nand_dq_i,
  input  logic              nand_rb
);
  logic              ce_force_q;
  logic [NBS_TW-1:0] timing_q;
  nbs_op_e           op_q;
  logic [DW-1:0]     byte_q;
  nbs_phase_e        phase;
  nbs_timing_t       tim_sel;
  logic              start;
  logic              pulse_last;

  // named internal events, observed by the bound checker
  logic ev_cyc_start;
  logic ev_cyc_end;
  logic ev_cur_read;

  assign busy         = (phase != PH_IDLE);
  assign req_ready    = !busy;
  assign start        = req_valid && !busy && !sw_reset;
  assign ev_cyc_start = start;
  assign ev_cur_read  = (op_q == OP_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_force_q <= 1'b0;
      timing_q   <= '0;
      op_q       <= OP_CMD;
      byte_q     <= '0;
    end else begin
      if (sw_reset)    ce_force_q <= 1'b0;
      else if (cfg_we) ce_force_q <= cfg_ce_low;
      if (tim_we) timing_q <= tim_word;
      if (start) begin
        op_q   <= nbs_op_e'(req_op);
        byte_q <= req_byte;
      end
    end
  end

  nbs_timing_select u_tsel (
    .word   (timing_q),
    .rd_dir (nbs_op_e'(req_op) == OP_RDATA),
    .sel    (tim_sel)
  );

  nbs_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .start      (start),
    .tim_sel    (tim_sel),
    .phase      (phase),
    .pulse_last (pulse_last),
    .cyc_end    (ev_cyc_end)
  );

  nbs_pin_drive #(.DW(DW)) u_pins (
    .phase    (phase),
    .op       (op_q),
    .byte_q   (byte_q),
    .ce_force (ce_force_q),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_o     (nand_dq_o),
    .dq_oe    (nand_dq_oe)
  );

  nbs_sampler #(.DW(DW)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .pulse_last (pulse_last),
    .rd_dir     (ev_cur_read),
    .cyc_end    (ev_cyc_end),
    .dq_i       (nand_dq_i),
    .rb         (nand_rb),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rdy_status (rdy_status)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_reset,
  input logic req_valid,
  input logic busy,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic rd_valid,
  input logic rdy_status,
  input logic ev_cyc_start,
  input logic ev_cyc_end,
  input logic ev_cur_read
);
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_dq_oe));

  p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_latch_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> busy);

  p_ce_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !nand_ce_n);

  p_read_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_cur_read) |-> !nand_dq_oe);

  p_rdvalid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_rdvalid_after_re_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!nand_re_n));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !sw_reset) |=> busy);

  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cyc_start |-> !busy);

  p_status_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdy_status) |-> $past(ev_cyc_end));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!busy && nand_ce_n));
endmodule

bind nand_bus_seq nbs_checker u_nbs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_reset     (sw_reset),
  .req_valid    (req_valid),
  .busy         (busy),
  .nand_ce_n    (nand_ce_n),
  .nand_cle     (nand_cle),
  .nand_ale     (nand_ale),
  .nand_we_n    (nand_we_n),
  .nand_re_n    (nand_re_n),
  .nand_dq_oe   (nand_dq_oe),
  .rd_valid     (rd_valid),
  .rdy_status   (rdy_status),
  .ev_cyc_start (ev_cyc_start),
  .ev_cyc_end   (ev_cyc_end),
  .ev_cur_read  (ev_cur_read)
);

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_reset = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_ce_low = 1'b0;
  logic        tim_we = 1'b0;
  logic [31:0] tim_word = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [7:0]  req_byte = '0;
  logic        req_ready, busy, rd_valid, rdy_status;
  logic [7:0]  rd_data, nand_dq_o;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] tw_cur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_seq u_nand_bus_seq (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .cfg_we(cfg_we), .cfg_ce_low(cfg_ce_low),
    .tim_we(tim_we), .tim_word(tim_word),
    .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte),
    .req_ready(req_ready), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .rdy_status(rdy_status),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // extract field f (0 setup,1 hold,2 width,3 wait) for a direction
  function automatic int fld(input logic [31:0] w, input bit rd, input int f);
    int sh;
    sh = (rd ? 0 : 16) + 4 * f;
    return int'((w >> sh) & 32'hF);
  endfunction

  task automatic set_tw(input logic [31:0] v);
    tim_word = v; tim_we = 1'b1;
    @(negedge clk);
    tim_we = 1'b0;
    tw_cur = v;
  endtask

  task automatic set_ce(input logic v);
    cfg_ce_low = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // run one request from a negedge; returns at a negedge with busy low
  task automatic run_op(input int op, input int byt, input logic rb_during,
                        input logic rb_final, input bit mid_change,
                        input logic [31:0] new_tw);
    int s, w, h, n, tot, k, pre, str, cle_c, ale_c, oe_c, dq_bad, ceh, rv_c, rv_idx, got;
    bit rd, seen;
    logic [31:0] twu;
    twu = tw_cur; rd = (op == 3);
    s = fld(twu, rd, 0); h = fld(twu, rd, 1); w = fld(twu, rd, 2); n = fld(twu, rd, 3);
    tot = s + w + h + 3 + 2 * n;
    pre = 0; str = 0; cle_c = 0; ale_c = 0; oe_c = 0; dq_bad = 0; ceh = 0;
    rv_c = 0; rv_idx = -1; got = -1; seen = 0;
    nand_rb = rb_during;
    req_valid = 1'b1; req_op = 2'(op); req_byte = 8'(byt);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (busy && k < 400) begin
      if (k == tot - 1) nand_rb = rb_final;
      nand_dq_i = 8'(byt + k);
      if (!nand_we_n || !nand_re_n) begin str++; seen = 1; end
      else if (!seen) pre++;
      if (nand_cle) cle_c++;
      if (nand_ale) ale_c++;
      if (nand_dq_oe) begin
        oe_c++;
        if (nand_dq_o != 8'(byt)) dq_bad++;
      end
      if (nand_ce_n) ceh++;
      if (rd_valid) begin rv_c++; rv_idx = k; got = int'(rd_data); end
      if (mid_change && k == 0) begin tim_word = new_tw; tim_we = 1'b1; end
      if (mid_change && k == 1) begin tim_we = 1'b0; tw_cur = new_tw; end
      k++;
      @(negedge clk);
    end
    check(k == tot, "R3 cycle length", k, tot);
    check(pre == s + 1, "R2 setup clocks", pre, s + 1);
    check(str == w + 1, "R1 strobe width field", str, w + 1);
    check(cle_c == ((op == 0) ? s + w + h + 3 : 0), "R4 CLE clocks", cle_c, (op == 0) ? s + w + h + 3 : 0);
    check(ale_c == ((op == 1) ? s + w + h + 3 : 0), "R4 ALE clocks", ale_c, (op == 1) ? s + w + h + 3 : 0);
    check(oe_c == (rd ? 0 : s + w + h + 3), "R5 drive clocks", oe_c, rd ? 0 : s + w + h + 3);
    check(dq_bad == 0, "R5 driven byte", dq_bad, 0);
    check(ceh == 0, "R7 CE low in cycle", ceh, 0);
    if (rd) begin
      check(rv_c == 1 && rv_idx == s + w + 2, "R6 rd_valid timing", rv_idx, s + w + 2);
      check(got == ((byt + s + 1 + w) & 255), "R6 captured byte", got, (byt + s + 1 + w) & 255);
    end else begin
      check(rv_c == 0, "R6 no rd_valid on write", rv_c, 0);
    end
    check(rdy_status == rb_final, "R8 sampled ready", int'(rdy_status), int'(rb_final));
    nand_rb = ~rb_final;
    @(negedge clk);
    check(rdy_status == rb_final, "R3 status held after cycle", int'(rdy_status), int'(rb_final));
  endtask

  initial begin
    logic [31:0] tw;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(busy == 0 && req_ready == 1, "R9 reset idle", int'(busy), 0);
    check(nand_ce_n == 1, "R7 reset CE high", int'(nand_ce_n), 1);
    check(nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale,
          "R12 reset bus quiet", int'({nand_we_n, nand_re_n, nand_dq_oe, nand_cle, nand_ale}), 24);
    check(rdy_status == 0 && rd_valid == 0, "R8 reset status", int'(rdy_status), 0);

    // sweep: six timing words, every request kind
    for (int c = 0; c < 6; c++) begin
      tw = '0;
      for (int f = 0; f < 8; f++) begin
        int v;
        v = (c == 0) ? 0 : (c == 5) ? 15 : ((c * 7 + f * 3) % 16);
        tw = tw | (32'(v) << (4 * f));
      end
      set_tw(tw);
      for (int op = 0; op < 4; op++)
        run_op(op, 8'h3C ^ (c * 16 + op), logic'(op % 2), logic'((c + op) % 2), 1'b0, '0);
    end

    // R10: timing rewrite during a cycle affects only the next one
    set_tw(32'h0201_0000 | 32'h0000_1101);
    run_op(2, 8'hA5, 1'b1, 1'b1, 1'b1, 32'h0701_0000 | 32'h0000_1101);
    run_op(2, 8'h5A, 1'b0, 1'b1, 1'b0, '0);
    check(tw_cur[27:24] == 4'd7, "R10 new word in use", int'(tw_cur[27:24]), 7);

    // R7: chip-enable hold while idle
    set_ce(1'b1);
    check(nand_ce_n == 0, "R7 CE held low idle", int'(nand_ce_n), 0);
    run_op(1, 8'h77, 1'b1, 1'b1, 1'b0, '0);
    check(nand_ce_n == 0, "R7 CE held low after cycle", int'(nand_ce_n), 0);
    set_ce(1'b0);
    check(nand_ce_n == 1, "R7 CE released idle", int'(nand_ce_n), 1);

    // R9: held request waits, taken after one idle clock
    set_tw(32'h0000_0000);
    req_valid = 1'b1; req_op = 2'd0; req_byte = 8'h11;
    @(negedge clk);
    req_byte = 8'h22;
    k = 0;
    while (busy && k < 100) begin
      check(nand_dq_o == 8'h11, "R9 held request not taken early", int'(nand_dq_o), 17);
      k++;
      @(negedge clk);
    end
    check(busy == 0 && req_ready == 1, "R9 idle gap before held request", int'(busy), 0);
    @(negedge clk);
    check(busy == 1 && nand_cle == 1 && nand_dq_o == 8'h22, "R9 held request taken",
          int'(nand_dq_o), 34);
    req_valid = 1'b0;
    while (busy) @(negedge clk);

    // R11: software reset mid-cycle
    set_ce(1'b1);
    set_tw(32'hFFFF_FFFF);
    req_valid = 1'b1; req_op = 2'd3; req_byte = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(nand_re_n == 0, "R11 reset lands in strobe", int'(nand_re_n), 0);
    sw_reset = 1'b1;
    @(negedge clk);
    sw_reset = 1'b0;
    check(busy == 0, "R11 idle after reset", int'(busy), 0);
    check(nand_ce_n == 1 && nand_re_n == 1 && nand_we_n == 1, "R11 bus released",
          int'({nand_ce_n, nand_re_n, nand_we_n}), 7);
    repeat (3) @(negedge clk);
    check(rd_valid == 0 && busy == 0, "R11 no late completion", int'(busy), 0);
    set_tw(32'h0000_0000);
    run_op(3, 8'h40, 1'b1, 1'b1, 1'b0, '0);

    finish_run();
  end
endmodule